// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters on a single line and hands them to a reader through a two-entry queue. Each queued character keeps its own framing and parity results, so the error flags seen by the reader always describe the character at the head. It does not pick a bit rate. An external divider supplies a one-cycle strobe at sixteen times the bit rate, and the receiver samples the line on that strobe. Character width can be set from five to eight data bits, and parity can be off, even or odd.

The line passes through a two-flop synchronizer before it reaches the receive state machine. The machine has six states. IDLE waits for a low sample on a strobe and then moves to START. START checks the middle of the start bit and goes back to IDLE on a false start, or moves on to DATA at the end of the bit. DATA collects the data bits and moves to PARITY when parity is on, or to STOP when it is off. PARITY evaluates the parity bit and then moves to STOP. At mid-bit, STOP goes to IDLE if the queue can accept the character, or to HOLD if it cannot. HOLD keeps the finished character in the shift register. It goes to IDLE once the character is pushed, or to START when a new start bit arrives first, which discards the held character and raises overrun. Clearing the enable forces IDLE, empties the queue and clears overrun.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, `avail` and `ovr` are both 0.
- R2: Data bits are received LSB first. The number of bits is 5 + `width_sel` (0 gives 5, 3 gives 8), and unused upper bits of `rd_data` read 0.
- R3: A start is detected by a low line on a tick. It is confirmed only if the majority of samples 7, 8 and 9 (counted from 0) of the 16-tick bit is low. If not confirmed, nothing is received. Every other bit also takes the majority of its samples 7 to 9.
- R4: `par_mode[1]`=1 turns parity on, and `par_mode[0]` selects odd (1) or even (0). One parity bit follows the data. A mismatch sets `rd_perr` for that character only.
- R5: While `par_mode[1]`=0, no parity bit is expected and `rd_perr` reads 0.
- R6: Only the first stop bit is checked. If it is sampled as 0, `rd_ferr` is set for that character.
- R7: The queue holds two characters, and a third finished character waits in the shift register. All three are delivered in arrival order.
- R8: `ovr` rises when the queue is full, a character is waiting, and a new start bit is detected. The waiting character is lost.
- R9: `ovr` clears when the next character is pushed into the queue.
- R10: A pulse on `rd_stb` while `avail`=0 has no effect.
- R11: While `rx_en`=0, any reception in progress is dropped, the queue is emptied and `ovr` is cleared.
- R12: A character may be pushed into a full queue in the same cycle as a read, and no character is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| par_mode | input | 2 | [1] parity on, [0] odd |
| width_sel | input | 2 | Data bits minus 5 |
| tick16 | input | 1 | Strobe at 16x the bit rate |
| rd_stb | input | 1 | Pops the head character |
| avail | output | 1 | Queue is not empty |
| rd_data | output | 8 | Head character data |
| rd_ferr | output | 1 | Head character framing error |
| rd_perr | output | 1 | Head character parity error |
| ovr | output | 1 | Overrun flag |

## Verification
A miscounted sample index moves the majority vote toward a bit edge. It shows up within one character as swapped or shifted data bits, or as a start that is wrongly rejected. A queue pointer or count that goes out of step with the data shows up on the next read as a repeated or missing character, or as error flags attached to the wrong data. Errors in the HOLD state show up during the fill-then-overflow sequence, either as `ovr` at the wrong moment or as the wrong character surviving.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int DATA_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                ferr;
        logic                perr;
    } rx_entry_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx,
    input  logic       tick,
    input  logic [1:0] par_mode,
    input  logic [1:0] width_sel,
    input  logic       space,
    output logic       push,
    output rx_entry_t  entry,
    output logic       ovr
);
    localparam int CNT_W = 4;
    localparam int IDX_W = $clog2(DATA_MAX);

    rx_state_t          state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   last_idx;
    logic [DATA_MAX-1:0] data_q;
    logic               v7, v8, maj, mid, bit_end;
    logic               ferr_q, perr_q;

    assign last_idx = IDX_W'(4) + IDX_W'(width_sel);
    assign maj      = (v7 & v8) | (v7 & rx) | (v8 & rx);
    assign mid      = tick && (cnt == CNT_W'(9));
    assign bit_end  = tick && (cnt == CNT_W'(15));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !rx) nxt = ST_START;
            ST_START:  if (mid && maj) nxt = ST_IDLE;
                       else if (bit_end) nxt = ST_DATA;
            ST_DATA:   if (bit_end && bit_idx == last_idx)
                           nxt = par_mode[1] ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) nxt = ST_STOP;
            ST_STOP:   if (mid) nxt = space ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (space) nxt = ST_IDLE;
                       else if (tick && !rx) nxt = ST_START;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            data_q  <= '0;
            v7      <= 1'b1;
            v8      <= 1'b1;
            ferr_q  <= 1'b0;
            perr_q  <= 1'b0;
            ovr     <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ovr   <= 1'b0;
        end else begin
            state <= nxt;
            if ((state == ST_IDLE || state == ST_HOLD) && nxt == ST_START) begin
                cnt     <= CNT_W'(1);
                bit_idx <= '0;
                data_q  <= '0;
                perr_q  <= 1'b0;
            end else if (tick && state != ST_IDLE && state != ST_HOLD) begin
                cnt <= cnt + 1'b1;
            end
            if (tick && cnt == CNT_W'(7)) v7 <= rx;
            if (tick && cnt == CNT_W'(8)) v8 <= rx;
            if (state == ST_DATA && mid)     data_q[bit_idx] <= maj;
            if (state == ST_DATA && bit_end) bit_idx <= bit_idx + 1'b1;
            if (state == ST_PARITY && mid)   perr_q <= maj ^ (^data_q) ^ par_mode[0];
            if (state == ST_STOP && mid)     ferr_q <= !maj;
            if (state == ST_HOLD && nxt == ST_START) ovr <= 1'b1;
            else if (push)                          ovr <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        push       = 1'b0;
        entry.data = data_q;
        entry.ferr = ferr_q;
        entry.perr = perr_q;
        unique case (state)
            ST_STOP: begin
                entry.ferr = !maj;
                push       = en && mid && space;
            end
            ST_HOLD: push = en && space;
            default: push = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      rd,
    output logic      space,
    output logic      nonempty,
    output logic      full,
    output rx_entry_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   count;
    logic            pop;

    assign nonempty = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign pop      = rd && nonempty;
    assign space    = !full || pop;
    assign head     = mem[rd_ptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= wrap_inc(wr_ptr);
            end
            if (pop) rd_ptr <= wrap_inc(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUEUE_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       rx_en,
    input  logic [1:0] par_mode,
    input  logic [1:0] width_sel,
    input  logic       tick16,
    input  logic       rd_stb,
    output logic       avail,
    output logic [7:0] rd_data,
    output logic       rd_ferr,
    output logic       rd_perr,
    output logic       ovr
);
    logic      rx_s, fr_push, q_space, q_full;
    rx_entry_t fr_entry, q_head;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    serial_rx_deframer u_deframer (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .rx(rx_s), .tick(tick16),
        .par_mode(par_mode), .width_sel(width_sel), .space(q_space),
        .push(fr_push), .entry(fr_entry), .ovr(ovr)
    );

    serial_rx_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(fr_push),
        .wr_entry(fr_entry), .rd(rd_stb), .space(q_space),
        .nonempty(avail), .full(q_full), .head(q_head)
    );

    assign rd_data = q_head.data;
    assign rd_ferr = q_head.ferr;
    assign rd_perr = q_head.perr & par_mode[1];
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic [1:0] par_mode,
    input logic       avail,
    input logic       rd_perr,
    input logic       ovr,
    input logic       rd_stb,
    input logic       push,
    input logic       full
);
    // R11
    flush_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !avail);

    // R5
    perr_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_mode[1] |-> !rd_perr);

    // R8
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !ovr);

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !avail && !push) |=> !avail);

    // R12
    push_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || rd_stb));
endmodule

bind serial_rx_fifo serial_rx_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_mode(par_mode),
    .avail(avail), .rd_perr(rd_perr), .ovr(ovr), .rd_stb(rd_stb),
    .push(fr_push), .full(q_full)
);

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] par_mode = 2'b00;
    logic [1:0] width_sel = 2'b11;
    logic       tick16 = 1'b0;
    logic       rd_stb = 1'b0;
    logic       avail, rd_ferr, rd_perr, ovr;
    logic [7:0] rd_data;

    int    checks = 0;
    int    fails = 0;
    logic  auto_rd = 1'b1;
    string cur_req = "R1";
    logic [9:0] exp_q[$];

    always #10 clk = ~clk;

    serial_rx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_en(rx_en),
        .par_mode(par_mode), .width_sel(width_sel), .tick16(tick16),
        .rd_stb(rd_stb), .avail(avail), .rd_data(rd_data),
        .rd_ferr(rd_ferr), .rd_perr(rd_perr), .ovr(ovr)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick16 = (div == 3);
            div = (div + 1) % 4;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic drive_bit(input logic v);
        rx_in = v;
        repeat (64) @(negedge clk);
    endtask

    // driver: pushes the expected item, then drives the frame
    task automatic send(input logic [7:0] d, input logic [1:0] ws, input logic [1:0] pm,
                        input logic stopv, input logic badp, input logic keep);
        int nb = 5 + int'(ws);
        logic [7:0] m = d & 8'((1 << nb) - 1);
        logic pbit = (^m) ^ pm[0] ^ badp;
        width_sel = ws;
        par_mode  = pm;
        if (keep) exp_q.push_back({m, !stopv, badp & pm[1]});
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (pm[1]) drive_bit(pbit);
        drive_bit(stopv);
        drive_bit(1'b1);
    endtask

    task automatic rd_one(input string r);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            chk({r, " queue empty"}, 32'(avail), 32'h0);
        end else begin
            e = exp_q.pop_front();
            chk(r, {rd_data, rd_ferr, rd_perr}, 32'(e));
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops and compares whenever a character is available
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && avail && rst_n) begin
                logic [9:0] e;
                if (exp_q.size() == 0) begin
                    chk({cur_req, " unexpected char"}, 32'(rd_data), 32'hFFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(cur_req, {rd_data, rd_ferr, rd_perr}, 32'(e));
                end
                rd_stb = 1'b1;
                @(negedge clk);
                rd_stb = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 avail", 32'(avail), 0);
        chk("R1 ovr", 32'(ovr), 0);

        cur_req = "R2";
        send(8'hA5, 2'd3, 2'b00, 1, 0, 1);
        send(8'h13, 2'd0, 2'b00, 1, 0, 1);
        send(8'h5A, 2'd2, 2'b00, 1, 0, 1);
        send(8'hFF, 2'd1, 2'b00, 1, 0, 1);

        cur_req = "R4";
        send(8'h3C, 2'd3, 2'b10, 1, 0, 1);
        send(8'h3C, 2'd3, 2'b10, 1, 1, 1);
        send(8'h71, 2'd3, 2'b11, 1, 0, 1);
        send(8'h71, 2'd3, 2'b11, 1, 1, 1);

        cur_req = "R5";
        send(8'h81, 2'd3, 2'b00, 1, 1, 1);
        chk("R5 perr", 32'(rd_perr), 0);

        cur_req = "R6";
        send(8'h55, 2'd3, 2'b00, 0, 0, 1);
        send(8'h2A, 2'd3, 2'b10, 0, 1, 1);
        chk("R6 drained", exp_q.size(), 0);

        // R3: short low pulse is rejected
        cur_req = "R3";
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (1000) @(negedge clk);
        chk("R3 glitch", 32'(avail), 0);

        // R10: read on empty queue
        auto_rd = 1'b0;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        chk("R10 empty", 32'(avail), 0);
        send(8'h96, 2'd3, 2'b00, 1, 0, 1);
        chk("R10 avail", 32'(avail), 1);
        rd_one("R10");
        chk("R10 empty after", 32'(avail), 0);

        // R7 / R12: two queued plus one waiting
        send(8'h11, 2'd3, 2'b00, 1, 0, 1);
        send(8'h22, 2'd3, 2'b00, 1, 0, 1);
        send(8'h33, 2'd3, 2'b00, 1, 0, 1);
        chk("R7 ovr", 32'(ovr), 0);
        rd_one("R7");
        rd_one("R12");
        rd_one("R7");
        chk("R7 empty", 32'(avail), 0);

        // R8 / R9: overrun drops the waiting character
        send(8'h44, 2'd3, 2'b00, 1, 0, 1);
        send(8'h55, 2'd3, 2'b00, 1, 0, 1);
        send(8'h66, 2'd3, 2'b00, 1, 0, 0);
        send(8'h77, 2'd3, 2'b00, 1, 0, 1);
        chk("R8 ovr", 32'(ovr), 1);
        rd_one("R8");
        chk("R9 ovr", 32'(ovr), 0);
        rd_one("R8");
        rd_one("R8");
        chk("R8 empty", 32'(avail), 0);

        // R11: disable flushes and aborts
        send(8'h01, 2'd3, 2'b00, 1, 0, 0);
        send(8'h02, 2'd3, 2'b00, 1, 0, 0);
        chk("R11 filled", 32'(avail), 1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 flushed", 32'(avail), 0);
        chk("R11 ovr", 32'(ovr), 0);
        rx_en = 1'b1;
        fork
            send(8'h0F, 2'd3, 2'b00, 1, 0, 0);
            begin
                repeat (300) @(negedge clk);
                rx_en = 1'b0;
            end
        join
        rx_en = 1'b1;
        repeat (200) @(negedge clk);
        chk("R11 aborted", 32'(avail), 0);
        auto_rd = 1'b1;
        cur_req = "R11";
        send(8'hC3, 2'd3, 2'b00, 1, 0, 1);
        repeat (20) @(negedge clk);
        chk("R11 drained", exp_q.size(), 0);

        finish_run();
    end
endmodule